// File: doc/BRIEF.md
# Display List Coprocessor Program Store and Sequencer

This block holds the program of a raster-synchronised display-list coprocessor and decides which instruction that coprocessor sees next. Software fills a 1K x 16 instruction store through three byte-wide registers. The store is addressed as 2K bytes. A data register takes the bytes. A pointer register gives the low eight bits of the byte address, and a control register gives the top three address bits together with a two-bit start mode. Each instruction arrives as two bytes, high byte first. The high byte waits in a staging register, and the whole 16-bit word is written into the store in one operation when the low byte arrives at the odd address.

A fetch index selects the word that drives the instruction output. The downstream decoder pulses a step strobe to move to the next instruction. The start mode decides whether the sequencer is idle, loops from word 0, resumes from the place it stopped, or returns to word 0 on every raster-origin pulse. A control write that repeats the current mode leaves the sequencer untouched, so software can move the load pointer without disturbing a running list.

Top module: `dlist_engine`

## Requirements
- R1: After reset the start mode is stop (running low), the fetch index is 0 and the byte pointer is 0.
- R2: A data write at an even byte address only captures the byte as the high half of a pending word; the stored instruction words stay unchanged.
- R3: A data write at an odd byte address stores {staged high byte, written byte} as one 16-bit word at word index = byte address shifted right by one.
- R4: Every data write advances the byte pointer by one, and the pointer wraps from 0x7FF to 0.
- R5: Register select 0 is control (bits 7:6 start mode, bits 2:0 load byte-address bits 10:8), select 1 loads byte-address bits 7:0, select 2 is the data byte, and select 3 does nothing.
- R6: In mode 00 the running output is low and step strobes leave the fetch index unchanged.
- R7: A control write that changes the mode to 01 sets the fetch index to 0, and this clear takes priority over a step in the same cycle. In a running mode each step adds one to the index, which wraps from word 1023 to word 0.
- R8: A control write that changes the mode to 10 keeps the fetch index where it stopped, and the sequencer runs on from there.
- R9: Entering mode 11 sets the index to 0. In mode 11 a raster-origin pulse sets the index to 0 and takes priority over a step. In the other modes the pulse has no effect.
- R10: A control write whose mode field equals the current mode does not change the fetch index.
- R11: The instruction output always shows the stored word at the current fetch index, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 pointer low, 2 data, 3 unused |
| regWrData | input | 8 | Register write byte |
| stepStrobe | input | 1 | Advance the fetch index by one |
| rasterOrigin | input | 1 | Pulse when the raster reaches position (0,0) |
| instrWord | output | 16 | Instruction word at the fetch index |
| fetchIndex | output | 10 | Current fetch word index |
| running | output | 1 | High when the start mode is not stop |

## Verification
The hardest case to reach is the wrap of the fetch index from word 1023 back to 0, together with the matching wrap of the byte pointer from 0x7FF. The bench uses a control write to place the pointer at 0x7FE and writes two words, so that the second one lands at word 0 after the wrap. It then starts the loop-from-zero mode and issues 1023 steps, checking the word fetched at the top of the store before the final step brings the index back to 0. Same-cycle collisions are also driven on purpose: a mode change together with a step, and a raster origin together with a step.

// File: rtl/dlist_pkg.sv
package dlist_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    MODE_STOP        = 2'b00,
    MODE_LOOP_ZERO   = 2'b01,
    MODE_LOOP_RESUME = 2'b10,
    MODE_RASTER      = 2'b11
  } startMode_e;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wordWe;
    logic pcClear;
    logic pcStep;
  } seqStrobes_t;
endpackage

// File: rtl/dlist_ctrl.sv
module dlist_ctrl
  import dlist_pkg::*;
#(
  parameter int BYTE_ADDR_W = 11,
  localparam int WORD_ADDR_W = BYTE_ADDR_W - 1,
  localparam int MSB_W = BYTE_ADDR_W - BYTE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [BYTE_W-1:0]      regWrData,
  input  logic                   stepStrobe,
  input  logic                   rasterOrigin,
  output seqStrobes_t            strobes,
  output logic [WORD_ADDR_W-1:0] wordAddr,
  output logic [WORD_W-1:0]      wordData,
  output startMode_e             curMode,
  output logic                   running
);
  logic [BYTE_ADDR_W-1:0] bytePtr;
  logic [BYTE_W-1:0]      stageByte;
  logic                   ctrlWr, addrLoWr, dataWr;
  startMode_e             newMode;
  logic                   modeChange, entryClear, originClear;

  always_comb begin
    ctrlWr   = regWrEn && (regSel == SEL_CTRL);
    addrLoWr = regWrEn && (regSel == SEL_ADDR_LO);
    dataWr   = regWrEn && (regSel == SEL_DATA);
    newMode  = startMode_e'(regWrData[7:6]);
  end

  // mode register: a repeated value is a no-op for the sequencer
  always_ff @(posedge clk) begin
    if (!rstN) curMode <= MODE_STOP;
    else if (ctrlWr) curMode <= newMode;
  end

  // byte pointer and staging register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePtr   <= '0;
      stageByte <= '0;
    end else begin
      if (ctrlWr) bytePtr[BYTE_ADDR_W-1:BYTE_W] <= regWrData[MSB_W-1:0];
      if (addrLoWr) bytePtr[BYTE_W-1:0] <= regWrData;
      if (dataWr) begin
        bytePtr <= bytePtr + 1'b1;
        if (!bytePtr[0]) stageByte <= regWrData;
      end
    end
  end

  always_comb begin
    modeChange  = ctrlWr && (newMode != curMode);
    entryClear  = modeChange &&
                  ((newMode == MODE_LOOP_ZERO) || (newMode == MODE_RASTER));
    originClear = (curMode == MODE_RASTER) && rasterOrigin;
    running     = (curMode != MODE_STOP);

    strobes.wordWe  = dataWr && bytePtr[0];
    strobes.pcClear = entryClear || originClear;
    strobes.pcStep  = stepStrobe && running;

    wordAddr = bytePtr[BYTE_ADDR_W-1:1];
    wordData = {stageByte, regWrData};
  end
endmodule

// File: rtl/dlist_datapath.sv
module dlist_datapath
  import dlist_pkg::*;
#(
  parameter int BYTE_ADDR_W = 11,
  localparam int WORD_ADDR_W = BYTE_ADDR_W - 1,
  localparam int DEPTH = 1 << WORD_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobes_t            strobes,
  input  logic [WORD_ADDR_W-1:0] wordAddr,
  input  logic [WORD_W-1:0]      wordData,
  output logic [WORD_ADDR_W-1:0] fetchIndex,
  output logic [WORD_W-1:0]      instrWord
);
  logic [WORD_W-1:0] progMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wordWe) progMem[wordAddr] <= wordData;
  end

  // clear outranks step; index wraps naturally at the top word
  always_ff @(posedge clk) begin
    if (!rstN) fetchIndex <= '0;
    else if (strobes.pcClear) fetchIndex <= '0;
    else if (strobes.pcStep) fetchIndex <= fetchIndex + 1'b1;
  end

  assign instrWord = progMem[fetchIndex];
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
  import dlist_pkg::*;
#(
  parameter int BYTE_ADDR_W = 11,
  localparam int WORD_ADDR_W = BYTE_ADDR_W - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [7:0]             regWrData,
  input  logic                   stepStrobe,
  input  logic                   rasterOrigin,
  output logic [15:0]            instrWord,
  output logic [WORD_ADDR_W-1:0] fetchIndex,
  output logic                   running
);
  seqStrobes_t            strobes;
  logic [WORD_ADDR_W-1:0] wordAddr;
  logic [WORD_W-1:0]      wordData;
  startMode_e             curMode;

  dlist_ctrl #(.BYTE_ADDR_W(BYTE_ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .stepStrobe(stepStrobe), .rasterOrigin(rasterOrigin),
    .strobes(strobes), .wordAddr(wordAddr), .wordData(wordData),
    .curMode(curMode), .running(running)
  );

  dlist_datapath #(.BYTE_ADDR_W(BYTE_ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordAddr(wordAddr),
    .wordData(wordData), .fetchIndex(fetchIndex), .instrWord(instrWord)
  );
endmodule

// File: rtl/dlist_checker.sv
module dlist_checker #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regSel,
  input logic [1:0]       wrMode,
  input logic             stepStrobe,
  input logic             rasterOrigin,
  input logic [IDX_W-1:0] fetchIndex,
  input logic             running,
  input logic [1:0]       curMode
);
  logic ctrlWr;
  assign ctrlWr = regWrEn && (regSel == 2'd0);

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !ctrlWr) |=> $stable(fetchIndex));

  a_r7_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    (running && stepStrobe && !ctrlWr && !(curMode == 2'b11 && rasterOrigin))
    |=> fetchIndex == IDX_W'($past(fetchIndex) + 1'b1));

  a_r7_entry_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrMode == 2'b01 && curMode != 2'b01) |=> fetchIndex == '0);

  a_r8_resume_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrMode == 2'b10 && curMode != 2'b10 && !stepStrobe && !rasterOrigin)
    |=> $stable(fetchIndex));

  a_r9_origin_restart: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b11 && rasterOrigin) |=> fetchIndex == '0);

  a_r10_same_mode_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrMode == curMode && !stepStrobe && !rasterOrigin)
    |=> $stable(fetchIndex));
endmodule

bind dlist_engine dlist_checker #(.IDX_W(WORD_ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .wrMode(regWrData[7:6]), .stepStrobe(stepStrobe), .rasterOrigin(rasterOrigin),
  .fetchIndex(fetchIndex), .running(running), .curMode(curMode)
);

// File: tb/test_dlist_engine.sv
module test_dlist_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [7:0]  regWrData = 8'd0;
  logic        stepStrobe = 1'b0;
  logic        rasterOrigin = 1'b0;
  logic [15:0] instrWord;
  logic [9:0]  fetchIndex;
  logic        running;

  int checks = 0;
  int errors = 0;
  logic [1:0] modeTb = 2'b00;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  dlist_engine i_dlist_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .stepStrobe(stepStrobe), .rasterOrigin(rasterOrigin),
    .instrWord(instrWord), .fetchIndex(fetchIndex), .running(running)
  );

  function automatic logic [15:0] wordVal(input int i);
    return {8'h5A ^ 8'(i * 7), 8'hC3 ^ 8'(i)};
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock of stimulus, driven after a falling edge
  task automatic drive(input logic en, input logic [1:0] sel, input logic [7:0] d,
                       input logic st, input logic org);
    regWrEn = en; regSel = sel; regWrData = d; stepStrobe = st; rasterOrigin = org;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 2'd3; stepStrobe = 1'b0; rasterOrigin = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] d);
    drive(1'b1, sel, d, 1'b0, 1'b0);
  endtask

  task automatic setMode(input logic [1:0] m);
    modeTb = m;
    writeReg(2'd0, {m, 6'b0});
  endtask

  task automatic setPointer(input logic [10:0] a);
    writeReg(2'd0, {modeTb, 3'b0, a[10:8]});
    writeReg(2'd1, a[7:0]);
  endtask

  task automatic writeWord(input logic [15:0] w);
    writeReg(2'd2, w[15:8]);
    writeReg(2'd2, w[7:0]);
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd3, 8'd0, 1'b1, 1'b0);
  endtask

  task automatic testReset;
    checkVal("R1 running", 32'(running), 32'd0);
    checkVal("R1 index", 32'(fetchIndex), 32'd0);
  endtask

  task automatic testLoadRun;
    setPointer(11'h000);
    for (int i = 0; i < 16; i++) writeWord(wordVal(i));
    setMode(2'b01);
    checkVal("R7 running", 32'(running), 32'd1);
    checkVal("R7 entry index", 32'(fetchIndex), 32'd0);
    checkVal("R11 word0", 32'(instrWord), 32'(wordVal(0)));
    for (int i = 1; i < 16; i++) begin
      stepN(1);
      checkVal("R7 step index", 32'(fetchIndex), 32'(i));
      checkVal("R3 R4 R11 word", 32'(instrWord), 32'(wordVal(i)));
    end
  endtask

  task automatic testStaging;
    setMode(2'b00);
    checkVal("R6 running low", 32'(running), 32'd0);
    stepN(2);
    checkVal("R6 step ignored", 32'(fetchIndex), 32'd15);
    setPointer(11'd30);
    writeReg(2'd2, 8'hEE);
    checkVal("R2 word unchanged", 32'(instrWord), 32'(wordVal(15)));
    setPointer(11'd31);
    writeReg(2'd2, 8'h11);
    checkVal("R3 commit", 32'(instrWord), 32'h0000EE11);
    writeReg(2'd3, 8'hFF);
    checkVal("R5 select 3 inert", 32'(instrWord), 32'h0000EE11);
  endtask

  task automatic testWrap;
    setPointer(11'h7FE);
    writeWord(16'hBEEF);
    writeWord(16'h1234);
    setMode(2'b01);
    checkVal("R4 pointer wrap", 32'(instrWord), 32'h00001234);
    stepN(1023);
    checkVal("R7 top index", 32'(fetchIndex), 32'd1023);
    checkVal("R5 high address bits", 32'(instrWord), 32'h0000BEEF);
    stepN(1);
    checkVal("R7 index wrap", 32'(fetchIndex), 32'd0);
  endtask

  task automatic testResume;
    stepN(3);
    setMode(2'b00);
    stepN(2);
    checkVal("R6 held", 32'(fetchIndex), 32'd3);
    setMode(2'b10);
    checkVal("R8 resume index", 32'(fetchIndex), 32'd3);
    checkVal("R8 running", 32'(running), 32'd1);
    stepN(1);
    checkVal("R8 step", 32'(fetchIndex), 32'd4);
    setMode(2'b10);
    checkVal("R10 rewrite 10", 32'(fetchIndex), 32'd4);
    drive(1'b0, 2'd3, 8'd0, 1'b0, 1'b1);
    checkVal("R9 origin ignored in 10", 32'(fetchIndex), 32'd4);
  endtask

  task automatic testRaster;
    setMode(2'b11);
    checkVal("R9 entry index", 32'(fetchIndex), 32'd0);
    stepN(3);
    drive(1'b0, 2'd3, 8'd0, 1'b0, 1'b1);
    checkVal("R9 origin restart", 32'(fetchIndex), 32'd0);
    stepN(2);
    setMode(2'b11);
    checkVal("R10 rewrite 11", 32'(fetchIndex), 32'd2);
    drive(1'b0, 2'd3, 8'd0, 1'b1, 1'b1);
    checkVal("R9 origin over step", 32'(fetchIndex), 32'd0);
  endtask

  task automatic testPriority;
    stepN(5);
    modeTb = 2'b01;
    drive(1'b1, 2'd0, 8'h40, 1'b1, 1'b0);
    checkVal("R7 clear over step", 32'(fetchIndex), 32'd0);
    stepN(2);
    drive(1'b0, 2'd3, 8'd0, 1'b0, 1'b1);
    checkVal("R9 origin ignored in 01", 32'(fetchIndex), 32'd2);
    setMode(2'b01);
    checkVal("R10 rewrite 01", 32'(fetchIndex), 32'd2);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadRun();
    testStaging();
    testWrap();
    testResume();
    testRaster();
    testPriority();
    finish();
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end
endmodule